// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block is one programmable cell of a logic fabric. A truth table of 2^K bits, held in configuration storage, is addressed by K logic inputs through a tree of 2:1 multiplexers, so the cell can compute any Boolean function of its inputs. A single mode bit then decides whether the cell output follows the table result directly, or a copy of it captured in a D flip-flop on the fabric clock.

The table and the mode bit are written through a one-wire serial port. While the load enable is high, one bit is taken on each rising clock edge into a shift chain. During loading the output is forced low and the flip-flop is held clear, so a half-written table never reaches the output. A synchronous reset clears only the flip-flop; the loaded function survives it.

As an example, the 16-bit table 0x6996 turns the default four-input cell into a four-input parity (XOR) gate.

Top module: `lutle_cell`

## Requirements
- R1: With the load enable low and the mode bit 0, `lut_out` equals table bit number i, where i is the binary value of `lut_in` (`lut_in[0]` is the least significant address bit).
- R2: In mode 0 the output follows a change of `lut_in` within the same clock cycle, with no clock edge in between.
- R3: In mode 1, after each rising edge with load enable and reset low, `lut_out` equals the table bit addressed by the `lut_in` value sampled at that edge, and it holds until the next edge even if `lut_in` changes.
- R4: A configuration frame is 2^K+1 bits. The mode bit is shifted first, then table bits from index 2^K-1 down to index 0, one bit per rising edge while `cfg_en` is high. If more bits are shifted, only the last 2^K+1 define the configuration.
- R5: While `cfg_en` is high, `lut_out` is 0 in both modes, starting in the same cycle `cfg_en` rises.
- R6: The flip-flop is cleared on every edge at which `cfg_en` is high. So in mode 1, `lut_out` is 0 from the fall of `cfg_en` until the next rising edge.
- R7: When `rst` is high at a rising edge, the flip-flop is cleared, so `lut_out` is 0 in mode 1. The table and mode bit are unchanged by reset, and configuration may be loaded while reset is high.
- R8: While `cfg_en` is low, `cfg_data` has no effect on the stored configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; flip-flop and shift chain update on its rising edge |
| rst | input | 1 | Synchronous reset of the output flip-flop, active high |
| cfg_en | input | 1 | Configuration load enable, active high |
| cfg_data | input | 1 | Serial configuration bit, sampled while `cfg_en` is high |
| lut_in | input | K | Logic inputs that address the truth table |
| lut_out | output | 1 | Cell output, combinational or registered per the mode bit |

## Verification
A wrong bit in the shift chain shows at the ports as one wrong output value, but only for the single input combination that addresses that bit. For this reason the test walks asymmetric tables and several input values per table. A mode bit stuck at the wrong value shows at once in the same cycle, because a registered output then lags an input change by one edge, or a combinational output responds too early. A flip-flop that is not cleared during loading or reset shows in the first cycle after `cfg_en` falls or after reset is released.

// File: rtl/lutle_pkg.sv
package lutle_pkg;

    // Output path selected by the top bit of the configuration frame
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // Frame length: one mode bit plus a full truth table
    function automatic int cfg_width(input int k);
        return (1 << k) + 1;
    endfunction

endpackage

// File: rtl/lutle_cfg_chain.sv
module lutle_cfg_chain #(
    parameter int CFG_W = 17
) (
    input  logic             clk,
    input  logic             cfg_en,
    input  logic             cfg_data,
    output logic [CFG_W-1:0] cfg_vec
);

    typedef struct packed {
        logic [CFG_W-1:0] vec;
    } chain_t;

    chain_t chain_d, chain_q;

    // Shift toward the MSB so the first bit shifted in ends up at the top
    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d.vec = {chain_q.vec[CFG_W-2:0], cfg_data};
        end
    end

    // Configuration storage is deliberately untouched by reset
    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign cfg_vec = chain_q.vec;

endmodule

// File: rtl/lutle_mux_tree.sv
module lutle_mux_tree #(
    parameter int K = 4,
    localparam int LEAVES = 1 << K
) (
    input  logic [LEAVES-1:0] tbl,
    input  logic [K-1:0]      sel,
    output logic              y
);

    // Level l halves the candidate set using input bit l
    for (genvar l = 0; l < K; l++) begin : g_lvl
        localparam int N_IN  = LEAVES >> l;
        localparam int N_OUT = LEAVES >> (l + 1);
        logic [N_IN-1:0]  src;
        logic [N_OUT-1:0] dst;

        if (l == 0) begin : g_leaf
            assign src = tbl;
        end else begin : g_inner
            assign src = g_lvl[l-1].dst;
        end

        for (genvar n = 0; n < N_OUT; n++) begin : g_node
            assign dst[n] = sel[l] ? src[2*n+1] : src[2*n];
        end
    end

    assign y = g_lvl[K-1].dst[0];

endmodule

// File: rtl/lutle_out_stage.sv
module lutle_out_stage
    import lutle_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_en,
    input  out_mode_e mode,
    input  logic      lut_val,
    output logic      lut_out
);

    typedef struct packed {
        logic ff;
    } ost_t;

    ost_t ost_d, ost_q;

    // Flip-flop is cleared by reset and throughout configuration
    always_comb begin
        ost_d = ost_q;
        if (rst || cfg_en) begin
            ost_d.ff = 1'b0;
        end else begin
            ost_d.ff = lut_val;
        end
    end

    always_ff @(posedge clk) begin
        ost_q <= ost_d;
    end

    always_comb begin
        if (cfg_en) begin
            lut_out = 1'b0;
        end else if (mode == OUT_REG) begin
            lut_out = ost_q.ff;
        end else begin
            lut_out = lut_val;
        end
    end

endmodule

// File: rtl/lutle_cell.sv
module lutle_cell
    import lutle_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_en,
    input  logic         cfg_data,
    input  logic [K-1:0] lut_in,
    output logic         lut_out
);

    localparam int TBL_W = 1 << K;
    localparam int CFG_W = cfg_width(K);

    logic [CFG_W-1:0] cfg_vec;
    logic [TBL_W-1:0] tbl_bits;
    out_mode_e        mode_sel;
    logic             lut_val;

    lutle_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .cfg_vec  (cfg_vec)
    );

    assign tbl_bits = cfg_vec[TBL_W-1:0];
    assign mode_sel = out_mode_e'(cfg_vec[CFG_W-1]);

    lutle_mux_tree #(.K(K)) u_tree (
        .tbl (tbl_bits),
        .sel (lut_in),
        .y   (lut_val)
    );

    lutle_out_stage u_ost (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .mode    (mode_sel),
        .lut_val (lut_val),
        .lut_out (lut_out)
    );

endmodule

// File: rtl/lutle_cell_chk.sv
module lutle_cell_chk
    import lutle_pkg::*;
#(
    parameter int K = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_en,
    input logic                 cfg_data,
    input logic [K-1:0]         lut_in,
    input logic                 lut_out,
    input logic [(1<<K):0]      cfg_vec,
    input logic [(1<<K)-1:0]    tbl,
    input out_mode_e            mode
);

    AST_COMB_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mode == OUT_COMB) |-> (lut_out == tbl[lut_in])); // R1

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ($past(!cfg_en && !rst) && !cfg_en && mode == OUT_REG)
            |-> (lut_out == $past(tbl[lut_in]))); // R3

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_vec[0] == $past(cfg_data))); // R4

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> !lut_out); // R5

    AST_POST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_en) && mode == OUT_REG) |-> !lut_out); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && $past(!cfg_en) && !cfg_en && mode == OUT_REG) |-> !lut_out); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_vec)); // R8

endmodule

bind lutle_cell lutle_cell_chk #(.K(K)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_data (cfg_data),
    .lut_in   (lut_in),
    .lut_out  (lut_out),
    .cfg_vec  (cfg_vec),
    .tbl      (tbl_bits),
    .mode     (mode_sel)
);

// File: tb/lutle_cell_test.sv
module lutle_cell_test;

    localparam int K       = 4;
    localparam int CLK_NS  = 4;
    localparam int MAX_CYC = 20000;
    localparam int NVEC    = 14;

    // {mode, table[15:0], lut_in[3:0], expected}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 16'h6996, 4'h0, 1'b0},
        {1'b0, 16'h6996, 4'h7, 1'b1},
        {1'b0, 16'h6996, 4'hB, 1'b1},
        {1'b0, 16'h8000, 4'hF, 1'b1},
        {1'b0, 16'h8000, 4'hE, 1'b0},
        {1'b0, 16'hFFFE, 4'h0, 1'b0},
        {1'b0, 16'hFFFE, 4'h4, 1'b1},
        {1'b0, 16'h00FF, 4'h7, 1'b1},
        {1'b0, 16'h00FF, 4'h8, 1'b0},
        {1'b1, 16'h0001, 4'h0, 1'b1},
        {1'b1, 16'h0001, 4'h8, 1'b0},
        {1'b1, 16'hA5C3, 4'h2, 1'b0},
        {1'b1, 16'hA5C3, 4'h6, 1'b1},
        {1'b1, 16'hA5C3, 4'hD, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_en = 1'b0;
    logic         cfg_data = 1'b0;
    logic [K-1:0] lut_in = '0;
    logic         lut_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    lutle_cell #(.K(K)) uut (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .lut_in   (lut_in),
        .lut_out  (lut_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: lut_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // Shift a frame, mode bit first, leaving cfg_en high
    task automatic shift_frame(input logic [16:0] frame);
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk);
            cfg_en   = 1'b1;
            cfg_data = frame[i];
        end
    endtask

    task automatic load_done();
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic load(input logic mode, input logic [15:0] tbl);
        shift_frame({mode, tbl});
        load_done();
    endtask

    initial begin
        #(MAX_CYC * CLK_NS);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run=timeout expected=complete");
        summary();
    end

    initial begin
        // Reset state; configuration is loaded while reset is high (R7)
        load(1'b1, 16'hFFFF);
        #1 check("R7 reset state", lut_out, 1'b0);
        @(posedge clk); #1 check("R7 held in reset", lut_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        #1 check("R7 before first capture", lut_out, 1'b0);
        @(posedge clk); #1 check("R3 first capture", lut_out, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 check("R7 reset clears flop", lut_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1 check("R7 config kept over reset", lut_out, 1'b1);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v][21], VEC[v][20:5]);
            lut_in = VEC[v][4:1];
            #1;
            if (VEC[v][21] == 1'b0) begin
                check("R1 R2 comb lookup", lut_out, VEC[v][0]);
            end else begin
                check("R6 cleared after load", lut_out, 1'b0);
                @(posedge clk); #1 check("R3 registered lookup", lut_out, VEC[v][0]);
            end
        end

        // R3: registered output holds across an input change inside a cycle
        load(1'b1, 16'h8000);
        lut_in = 4'hF;
        @(posedge clk); #1 check("R3 captured", lut_out, 1'b1);
        @(negedge clk); lut_in = 4'h0;
        #1 check("R3 hold mid-cycle", lut_out, 1'b1);
        @(posedge clk); #1 check("R3 next capture", lut_out, 1'b0);

        // R2: combinational output follows input without an edge
        load(1'b0, 16'h0F0F);
        lut_in = 4'h1;
        #1 check("R2 follow a", lut_out, 1'b1);
        lut_in = 4'h5;
        #1 check("R2 follow b", lut_out, 1'b0);

        // R5: raising cfg_en forces 0 in the same cycle
        load(1'b0, 16'hFFFF);
        lut_in = 4'h3;
        #1 check("R5 before load", lut_out, 1'b1);
        @(negedge clk); cfg_en = 1'b1; cfg_data = 1'b1;
        #1 check("R5 same cycle", lut_out, 1'b0);
        @(posedge clk); #1 check("R5 after shift", lut_out, 1'b0);
        // one shift moved table MSB (1) into the mode bit: now registered
        @(negedge clk); cfg_en = 1'b0;
        #1 check("R6 flop clear after load", lut_out, 1'b0);
        @(posedge clk); #1 check("R4 shifted mode bit", lut_out, 1'b1);

        // R8: cfg_data toggling with cfg_en low changes nothing
        load(1'b0, 16'h6996);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            cfg_data = c[0];
            lut_in   = 4'(c);
            #1 check("R8 table unchanged", lut_out, ^lut_in);
        end
        @(negedge clk); lut_in = 4'hE;
        #1 check("R8 table unchanged final", lut_out, 1'b1);

        // R4: overlong load keeps only the last frame
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            cfg_en   = 1'b1;
            cfg_data = 1'b1;
        end
        shift_frame({1'b0, 16'h0002});
        load_done();
        lut_in = 4'h1;
        #1 check("R4 overlong bit1", lut_out, 1'b1);
        lut_in = 4'h0;
        #1 check("R4 overlong bit0", lut_out, 1'b0);
        lut_in = 4'hF;
        #1 check("R4 overlong bit15", lut_out, 1'b0);

        @(negedge clk);
        summary();
    end

endmodule